// File: doc/BRIEF.md
# Peripheral Sense-and-Jump Unit

This unit carries out the conditional branch of a small 16-bit processor whose condition lives outside the core. A status line inside a peripheral is chosen by a 9-bit condition code. The code is driven onto a shared I/O bus, and the device that owns the line answers true or false. The sequencer hands the unit three things: the decoded instruction's code, the address of the instruction word, and the word that follows it, which holds the jump address.

On a true answer the program counter takes the jump address. When bit 15 of that word is set, the address is first resolved through one extra memory read. On a false answer execution continues past the jump-address word, at the instruction address plus two. The result is presented once, as a one-cycle program-counter load with a done pulse. No other processor state is touched.

Top module: `sense_jump_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy_o, bus_drive_o, mem_rd_o, pc_load_o and done_o are all 0, and bus_code_o is 0.
- R2: A start_i seen while idle is accepted at that clock edge. In the two cycles that follow, bus_drive_o is 1 and bus_code_o carries the code unchanged: bits 8..6 select the status line and bits 5..0 select the device.
- R3: The reply is taken only at the clock edge that ends the second drive cycle. A reply that is high only in the first drive cycle has no effect, and a device that does not answer reads as false.
- R4: On a true reply with bit 15 of the jump word clear, pc_load_o and done_o are 1 in the cycle after the sample, with pc_o equal to jump word bits 14..0.
- R5: On a false reply, pc_load_o and done_o are 1 in the cycle after the sample, with pc_o equal to the instruction address plus 2 modulo 2^15.
- R6: On a true reply with bit 15 set, mem_rd_o is 1 for exactly one cycle, the cycle after the sample, with mem_addr_o equal to jump word bits 14..0. mem_data_i is taken in the following cycle, and in the cycle after that pc_o equals mem_data_i bits 14..0; bit 15 of the fetched word is ignored.
- R7: On a false reply, no memory read is issued, whatever the value of bit 15.
- R8: done_o and pc_load_o are single-cycle pulses, raised once per accepted instruction and at no other time.
- R9: A start_i that arrives while busy_o is 1 is ignored. The code on the bus does not change, and no second operation follows.
- R10: Whenever bus_drive_o is 0, bus_code_o is 0. busy_o is 0 in the cycle after done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start_i | input | 1 | Decoded sense-and-jump instruction present |
| code_i | input | 9 | Condition code: line in bits 8..6, device in bits 5..0 |
| here_pc_i | input | 15 | Address of the sense instruction word |
| jump_word_i | input | 16 | Following word: bit 15 indirect flag, bits 14..0 address |
| bus_drive_o | output | 1 | Code is being driven on the shared I/O bus |
| bus_code_o | output | 9 | Condition code on the bus, 0 when not driving |
| bus_reply_i | input | 1 | True/false answer from the addressed device (pulled low) |
| mem_rd_o | output | 1 | Indirect read request |
| mem_addr_o | output | 15 | Indirect read address |
| mem_data_i | input | 16 | Read data, valid the cycle after mem_rd_o |
| busy_o | output | 1 | Operation in progress |
| pc_load_o | output | 1 | Load program counter with pc_o |
| pc_o | output | 15 | New program counter value |
| done_o | output | 1 | Update complete pulse |

## Verification
The bench builds the unit with its defaults: a 15-bit address, a 16-bit word with bit 15 as the indirect flag, and a 3+6-bit code. With a 15-bit address, sequential targets at 0x7FFE and 0x7FFF are within reach, so the wrap of the plus-two step is exercised. The peripheral model answers only for chosen line/device pairs. A code that names the right device on the wrong line therefore reads as false, and a reply pulse confined to the first drive cycle shows that only the second drive cycle is sampled. The memory model returns words with bit 15 both set and clear, which shows that indirection stops after one level.

// File: rtl/sj_pkg.sv
package sj_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DRIVE  = 3'd1,
    ST_SENSE  = 3'd2,
    ST_FETCH  = 3'd3,
    ST_INDATA = 3'd4,
    ST_UPDATE = 3'd5
  } sj_state_e;
endpackage

// File: rtl/sj_ctrl.sv
module sj_ctrl
  import sj_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic reply_i,
  input  logic ind_i,
  output logic accept_o,
  output logic take_sense_o,
  output logic take_mem_o,
  output logic hit_o,
  output logic busy_o,
  output logic drive_o,
  output logic mem_rd_o,
  output logic done_o
);
  sj_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_DRIVE;
      ST_DRIVE:  state_d = ST_SENSE;
      ST_SENSE:  state_d = (reply_i && ind_i) ? ST_FETCH : ST_UPDATE;
      ST_FETCH:  state_d = ST_INDATA;
      ST_INDATA: state_d = ST_UPDATE;
      ST_UPDATE: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign accept_o     = (state_q == ST_IDLE) && start_i;
  assign take_sense_o = (state_q == ST_SENSE);
  assign take_mem_o   = (state_q == ST_INDATA);
  assign hit_o        = take_sense_o && reply_i;
  assign busy_o       = (state_q != ST_IDLE);
  assign drive_o      = (state_q == ST_DRIVE) || (state_q == ST_SENSE);
  assign mem_rd_o     = (state_q == ST_FETCH);
  assign done_o       = (state_q == ST_UPDATE);

  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R6: indirect read lasts one cycle and is followed by the data cycle
  assert_mem_rd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> (!mem_rd_o && take_mem_o));
  // R6/R7: a read is only issued for an indirect jump word
  assert_read_needs_ind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> ind_i);
endmodule

// File: rtl/sj_bus.sv
module sj_bus #(
  parameter int CODE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              busy_i,
  input  logic              drive_i,
  input  logic              take_sense_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              bus_reply_i,
  output logic [CODE_W-1:0] bus_code_o,
  output logic              reply_o
);
  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;

  assign code_en = accept_i;

  always_comb begin
    code_d = code_q;
    if (code_en) code_d = code_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign bus_code_o = drive_i ? code_q : '0;
  // only the second drive cycle qualifies the answer
  assign reply_o    = take_sense_i && bus_reply_i;

  // R9: latched code cannot change during an operation
  assert_code_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && $past(busy_i)) |-> $stable(code_q));
  // R2: drive only happens inside a busy operation
  assert_drive_in_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drive_i |-> busy_i);
endmodule

// File: rtl/sj_target.sv
module sj_target #(
  parameter int ADDR_W  = 15,
  parameter int WORD_W  = 16,
  parameter int IND_BIT = WORD_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              hit_i,
  input  logic              take_mem_i,
  input  logic [ADDR_W-1:0] here_pc_i,
  input  logic [WORD_W-1:0] jump_word_i,
  input  logic [WORD_W-1:0] mem_data_i,
  output logic              ind_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] target_o
);
  localparam logic [ADDR_W-1:0] SKIP = ADDR_W'(2);

  logic [WORD_W-1:0] word_q, word_d;
  logic [ADDR_W-1:0] tgt_q, tgt_d;
  logic              word_en, tgt_en;

  assign word_en = accept_i;
  assign tgt_en  = accept_i || hit_i || take_mem_i;

  always_comb begin
    word_d = word_q;
    if (word_en) word_d = jump_word_i;
  end

  always_comb begin
    tgt_d = tgt_q;
    if (tgt_en) begin
      if (accept_i)        tgt_d = here_pc_i + SKIP;
      else if (hit_i)      tgt_d = word_q[ADDR_W-1:0];
      else                 tgt_d = mem_data_i[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      tgt_q  <= '0;
    end else begin
      word_q <= word_d;
      tgt_q  <= tgt_d;
    end
  end

  assign ind_o      = word_q[IND_BIT];
  assign mem_addr_o = word_q[ADDR_W-1:0];
  assign target_o   = tgt_q;

  // R6: indirect result is the fetched address field, not its flag
  assert_ind_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_mem_i |=> (tgt_q == $past(mem_data_i[ADDR_W-1:0])));
  // R4: a true reply selects the stored jump address
  assert_hit_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> (tgt_q == $past(word_q[ADDR_W-1:0])));
endmodule

// File: rtl/sense_jump_unit.sv
module sense_jump_unit #(
  parameter int ADDR_W = 15,
  parameter int WORD_W = 16,
  parameter int LINE_W = 3,
  parameter int DEV_W  = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [LINE_W+DEV_W-1:0]   code_i,
  input  logic [ADDR_W-1:0]         here_pc_i,
  input  logic [WORD_W-1:0]         jump_word_i,
  output logic                      bus_drive_o,
  output logic [LINE_W+DEV_W-1:0]   bus_code_o,
  input  logic                      bus_reply_i,
  output logic                      mem_rd_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  input  logic [WORD_W-1:0]         mem_data_i,
  output logic                      busy_o,
  output logic                      pc_load_o,
  output logic [ADDR_W-1:0]         pc_o,
  output logic                      done_o
);
  localparam int CODE_W  = LINE_W + DEV_W;
  localparam int IND_BIT = WORD_W - 1;

  logic accept, take_sense, take_mem, hit, reply, ind, drive, done;

  sj_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .reply_i      (reply),
    .ind_i        (ind),
    .accept_o     (accept),
    .take_sense_o (take_sense),
    .take_mem_o   (take_mem),
    .hit_o        (hit),
    .busy_o       (busy_o),
    .drive_o      (drive),
    .mem_rd_o     (mem_rd_o),
    .done_o       (done)
  );

  sj_bus #(.CODE_W(CODE_W)) u_bus (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_i     (accept),
    .busy_i       (busy_o),
    .drive_i      (drive),
    .take_sense_i (take_sense),
    .code_i       (code_i),
    .bus_reply_i  (bus_reply_i),
    .bus_code_o   (bus_code_o),
    .reply_o      (reply)
  );

  sj_target #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .IND_BIT(IND_BIT)) u_target (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .hit_i       (hit),
    .take_mem_i  (take_mem),
    .here_pc_i   (here_pc_i),
    .jump_word_i (jump_word_i),
    .mem_data_i  (mem_data_i),
    .ind_o       (ind),
    .mem_addr_o  (mem_addr_o),
    .target_o    (pc_o)
  );

  assign bus_drive_o = drive;
  assign done_o      = done;
  assign pc_load_o   = done;

  // R10: an idle unit leaves the shared bus quiet
  assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!bus_drive_o && bus_code_o == '0));
  // R10: unit returns to idle right after the update
  assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  // R9: a start while busy does not restart the drive phase
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !bus_drive_o) |=> !(bus_drive_o && !$past(bus_drive_o) && $past(busy_o)));
endmodule

// File: tb/test_sense_jump_unit.sv
module test_sense_jump_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;
  localparam int WW = 16;
  localparam int CW = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [CW-1:0] code;
  logic [AW-1:0] here;
  logic [WW-1:0] jword;
  logic          bus_drive;
  logic [CW-1:0] bus_code;
  logic          bus_reply;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_data;
  logic          busy, pc_load, done;
  logic [AW-1:0] pc;

  logic [511:0]  status_map;
  logic          first_ph, glitch;
  logic [AW-1:0] exp_q[$];
  int            checks = 0;
  int            errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sense_jump_unit i_sense_jump_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start), .code_i(code),
    .here_pc_i(here), .jump_word_i(jword), .bus_drive_o(bus_drive),
    .bus_code_o(bus_code), .bus_reply_i(bus_reply), .mem_rd_o(mem_rd),
    .mem_addr_o(mem_addr), .mem_data_i(mem_data), .busy_o(busy),
    .pc_load_o(pc_load), .pc_o(pc), .done_o(done)
  );

  function automatic logic [WW-1:0] mem_fn(input logic [AW-1:0] a);
    return {a[3], a ^ 15'h2D4B};
  endfunction

  // peripheral model: only listed line/device pairs answer true
  assign bus_reply = bus_drive && (first_ph ? glitch : status_map[bus_code]);

  always @(posedge clk) if (mem_rd) mem_data <= mem_fn(mem_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected program counter values on each update pulse
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected done", 32'(pc), 0);
        else begin
          logic [AW-1:0] e;
          e = exp_q.pop_front();
          chk(pc == e && pc_load, "R4/R5/R6 pc value", 32'(pc), 32'(e));
        end
      end
    end
  end

  task automatic run_op(input logic [CW-1:0] c, input logic [AW-1:0] h,
                        input logic [WW-1:0] w, input bit glt, input bit poke,
                        input string tag);
    bit hit, ind;
    logic [AW-1:0] e;
    hit = status_map[c];
    ind = w[WW-1];
    e = !hit ? AW'(h + 15'd2) : (ind ? mem_fn(w[AW-1:0])[AW-1:0] : w[AW-1:0]);
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b1; code = c; here = h; jword = w;
    @(negedge clk);                        // drive cycle 1
    first_ph = 1'b1; glitch = glt;
    start = poke; code = ~c; here = ~h; jword = ~w;
    chk(bus_drive && bus_code == c && busy, {"R2 drive 1 ", tag}, 32'(bus_code), 32'(c));
    @(negedge clk);                        // drive cycle 2
    first_ph = 1'b0; glitch = 1'b0; start = 1'b0;
    chk(bus_drive && bus_code == c, {"R2/R9 drive 2 ", tag}, 32'(bus_code), 32'(c));
    @(negedge clk);                        // cycle after sample
    if (hit && ind) begin
      chk(mem_rd && mem_addr == w[AW-1:0], {"R6 read ", tag}, 32'(mem_addr), 32'(w[AW-1:0]));
      @(negedge clk);
      chk(!mem_rd && !done, {"R6 data cycle ", tag}, 32'(mem_rd), 0);
      @(negedge clk);
    end else begin
      chk(!mem_rd, {"R7 no read ", tag}, 32'(mem_rd), 0);
    end
    chk(done && pc_load, {"R8 done timing ", tag}, 32'(done), 1);
    @(negedge clk);
    chk(!done && !pc_load && !busy && !bus_drive && bus_code == 0,
        {"R10/R9 idle after ", tag}, 32'({done, busy, bus_drive}), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; code = '0; here = '0; jword = '0;
    first_ph = 1'b0; glitch = 1'b0; status_map = '0;
    status_map[{3'd5, 6'd3}]  = 1'b1;
    status_map[{3'd0, 6'd63}] = 1'b1;
    status_map[{3'd7, 6'd12}] = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !bus_drive && !mem_rd && !done && !pc_load && bus_code == 0,
        "R1 reset state", 32'({busy, bus_drive, mem_rd, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !bus_drive && !done && bus_code == 0, "R1 after release",
        32'({busy, bus_drive, done}), 0);
    run_op({3'd5, 6'd3},  15'h0100, 16'h0ABC, 1'b0, 1'b0, "R4 hit direct");
    run_op({3'd4, 6'd3},  15'h0200, 16'h0ABC, 1'b0, 1'b0, "R5 wrong line");
    run_op({3'd0, 6'd63}, 15'h0300, 16'h8123, 1'b0, 1'b0, "R6 hit indirect");
    run_op({3'd7, 6'd12}, 15'h0400, 16'h8008, 1'b0, 1'b0, "R6 flag ignored");
    run_op({3'd1, 6'd20}, 15'h0500, 16'h8777, 1'b0, 1'b0, "R7 miss indirect");
    run_op({3'd1, 6'd20}, 15'h0600, 16'h0123, 1'b1, 1'b0, "R3 early reply");
    run_op({3'd5, 6'd3},  15'h0700, 16'h0456, 1'b0, 1'b1, "R9 start busy");
    run_op({3'd2, 6'd9},  15'h7FFF, 16'h0001, 1'b0, 1'b0, "R5 wrap 7FFF");
    run_op({3'd2, 6'd9},  15'h7FFE, 16'h0001, 1'b0, 1'b1, "R5 wrap 7FFE");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all updates seen", 32'(exp_q.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule